// File: doc/BRIEF.md
# Threshold Word-Error Histogram Counter

This block sits behind a frame-to-frame sample comparator in a converter test path. It receives a stream of absolute difference magnitudes, one per strobe at the reduced processing rate, and keeps a set of parallel counters. Each counter has its own programmable threshold. A counter advances by one for every strobed magnitude that is at or above its threshold. Read together, the counters give a coarse histogram of how large the word errors were.

The threshold test does not use a magnitude comparator. The threshold is subtracted from the latched magnitude one bit wider than the data, and the inverted sign bit of that difference is the increment. Each faulty word is seen twice, once against the frame before it and once against the frame after it. For that reason every channel also reports a halved count next to its raw count. Counters saturate instead of wrapping. A synchronous clear input zeroes all of them without a full reset.

Top module: `mag_threshold_counter`

## Requirements
- R1: While reset is high and after it is released, every raw count and every halved count reads zero until a qualifying sample is counted.
- R2: A magnitude strobed with `mag_valid` high in clock cycle t raises the raw count of channel k by exactly one, visible after the second rising edge (t+1), when the magnitude is greater than or equal to that channel's threshold (unsigned compare).
- R3: A strobed magnitude strictly below a channel's threshold leaves that channel unchanged. This holds across the full range: with threshold 16'hFFFF, magnitude 16'hFFFE is not counted and 16'hFFFF is counted.
- R4: Cycles with `mag_valid` low change no count, whatever value `mag` carries.
- R5: Channels are independent. One magnitude advances every channel whose threshold it reaches and no other channel.
- R6: A channel's threshold is sampled in the same cycle as the magnitude. Changing the threshold in a later cycle does not alter the decision for that sample.
- R7: Each halved count equals its raw count shifted right by one bit (floor of raw/2).
- R8: `clear` high in a cycle zeroes all counts at the following edge. An increment due at that same edge is dropped. A sample strobed in the clear cycle is still counted one edge later.
- R9: A raw count at its all-ones value stays there on further qualifying samples.
- R10: A threshold of zero counts every strobed sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous zeroing of all counters |
| mag_valid | input | 1 | Strobe qualifying `mag` this cycle |
| mag | input | MAG_W | Unsigned absolute difference magnitude |
| thr_flat | input | NUM_TH*MAG_W | Thresholds; channel k at bits [k*MAG_W +: MAG_W] |
| raw_counts | output | NUM_TH*CNT_W | Raw counts; channel k at bits [k*CNT_W +: CNT_W] |
| half_counts | output | NUM_TH*CNT_W | Raw counts shifted right by one, same packing |

## Verification
The two functions that can meet in one cycle are a synchronous clear and a counter increment coming from the previous strobe. The bench strobes a qualifying magnitude and raises `clear` in the very next cycle, so both act on the same edge. It expects every count to read zero afterwards. It then strobes a sample while `clear` is high and expects that sample to appear one edge after the clear. This shows the capture stage is not flushed by the clear.

// File: rtl/wec_pkg.sv
package wec_pkg;

    localparam int unsigned DEF_MAG_W  = 16;
    localparam int unsigned DEF_CNT_W  = 48;
    localparam int unsigned DEF_NUM_TH = 4;

    // Action a channel counter takes on an edge
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_WIPE = 2'd2
    } cnt_op_e;

    // Select the counter action; clear dominates any pending increment
    function automatic cnt_op_e pick_op(input logic wipe, input logic inc, input logic at_max);
        if (wipe)
            return OP_WIPE;
        else if (inc && !at_max)
            return OP_STEP;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/wec_capture.sv
module wec_capture #(
    parameter int unsigned MAG_W  = 16,
    parameter int unsigned NUM_TH = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mag_valid,
    input  logic [MAG_W-1:0]        mag,
    input  logic [NUM_TH*MAG_W-1:0] thr_flat,
    output logic                    smp_vld,
    output logic [MAG_W-1:0]        smp_mag,
    output logic [NUM_TH*MAG_W-1:0] smp_thr
);

    localparam int unsigned THR_BITS = NUM_TH * MAG_W;

    typedef struct packed {
        logic                vld;
        logic [MAG_W-1:0]    mag;
        logic [THR_BITS-1:0] thr;
    } sample_t;

    sample_t stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q.vld <= mag_valid;
            if (mag_valid) begin
                stage_q.mag <= mag;
                stage_q.thr <= thr_flat;
            end
        end
    end

    assign smp_vld = stage_q.vld;
    assign smp_mag = stage_q.mag;
    assign smp_thr = stage_q.thr;

endmodule

// File: rtl/wec_compare.sv
module wec_compare #(
    parameter int unsigned MAG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  logic [MAG_W-1:0] mag,
    input  logic [MAG_W-1:0] thr,
    output logic             hit
);

    localparam int unsigned DIFF_W = MAG_W + 1;

    logic [DIFF_W-1:0] diff;

    // Extra bit keeps the sign correct over the full unsigned range
    always_comb begin
        diff = {1'b0, mag} - {1'b0, thr};
        hit  = vld & ~diff[DIFF_W-1];
    end

    // R2/R3: sign-bit decision agrees with an ordinary unsigned compare
    assert_sign_matches_R3: assert property (@(posedge clk) disable iff (rst)
        vld |-> (hit == (mag >= thr)));

endmodule

// File: rtl/wec_counter.sv
module wec_counter #(
    parameter int unsigned CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    import wec_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    cnt_op_e          op;

    always_comb op = pick_op(clear, inc, cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                OP_WIPE: cnt_q <= '0;
                OP_STEP: cnt_q <= cnt_q + CNT_ONE;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign count = cnt_q;

    // R2: without clear the count moves by at most one per edge
    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_ONE));

    // R8: clear empties the counter on the next edge
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));

    // R9: a full counter never wraps
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !clear) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/mag_threshold_counter.sv
module mag_threshold_counter #(
    parameter int unsigned MAG_W  = wec_pkg::DEF_MAG_W,
    parameter int unsigned CNT_W  = wec_pkg::DEF_CNT_W,
    parameter int unsigned NUM_TH = wec_pkg::DEF_NUM_TH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    mag_valid,
    input  logic [MAG_W-1:0]        mag,
    input  logic [NUM_TH*MAG_W-1:0] thr_flat,
    output logic [NUM_TH*CNT_W-1:0] raw_counts,
    output logic [NUM_TH*CNT_W-1:0] half_counts
);

    logic                    smp_vld;
    logic [MAG_W-1:0]        smp_mag;
    logic [NUM_TH*MAG_W-1:0] smp_thr;
    logic [NUM_TH-1:0]       hits;

    wec_capture #(
        .MAG_W (MAG_W),
        .NUM_TH(NUM_TH)
    ) u_capture (
        .clk      (clk),
        .rst      (rst),
        .mag_valid(mag_valid),
        .mag      (mag),
        .thr_flat (thr_flat),
        .smp_vld  (smp_vld),
        .smp_mag  (smp_mag),
        .smp_thr  (smp_thr)
    );

    for (genvar k = 0; k < NUM_TH; k++) begin : g_chan
        logic [CNT_W-1:0] cnt;

        wec_compare #(
            .MAG_W(MAG_W)
        ) u_cmp (
            .clk(clk),
            .rst(rst),
            .vld(smp_vld),
            .mag(smp_mag),
            .thr(smp_thr[k*MAG_W +: MAG_W]),
            .hit(hits[k])
        );

        wec_counter #(
            .CNT_W(CNT_W)
        ) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .clear(clear),
            .inc  (hits[k]),
            .count(cnt)
        );

        assign raw_counts[k*CNT_W +: CNT_W]  = cnt;
        assign half_counts[k*CNT_W +: CNT_W] = {1'b0, cnt[CNT_W-1:1]};
    end

    // R4: an idle capture stage never raises a hit
    assert_idle_no_hit_R4: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |-> (hits == '0));

endmodule

// File: tb/mag_threshold_counter_test.sv
module mag_threshold_counter_test;

    localparam int MW = 16;
    localparam int CW = 5;
    localparam int NT = 4;
    localparam int CMAX = (1 << CW) - 1;

    typedef struct {
        int    raw[NT];
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clear = 1'b0;
    logic mag_valid = 1'b0;
    logic [MW-1:0] mag = '0;
    logic [NT*MW-1:0] thr_flat = '0;
    logic [NT*CW-1:0] raw_counts;
    logic [NT*CW-1:0] half_counts;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [MW-1:0] thr [NT];
    int  model [NT];
    bit  pend  [NT];
    exp_t sb_q [$];

    always #4 clk = ~clk;

    mag_threshold_counter #(.MAG_W(MW), .CNT_W(CW), .NUM_TH(NT)) uut (
        .clk(clk), .rst(rst), .clear(clear), .mag_valid(mag_valid),
        .mag(mag), .thr_flat(thr_flat),
        .raw_counts(raw_counts), .half_counts(half_counts)
    );

    task automatic push_exp(input string tag);
        exp_t e;
        for (int k = 0; k < NT; k++) e.raw[k] = model[k];
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic do_reset(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst = 1'b1; mag_valid = 1'b0; clear = 1'b0;
            for (int k = 0; k < NT; k++) begin model[k] = 0; pend[k] = 0; end
            push_exp("R1");
        end
    endtask

    // Drive one cycle and predict the counts after its edge
    task automatic drive(input bit v, input logic [MW-1:0] mg, input bit clr, input string tag);
        @(negedge clk);
        rst = 1'b0; mag_valid = v; mag = mg; clear = clr;
        for (int k = 0; k < NT; k++) thr_flat[k*MW +: MW] = thr[k];
        for (int k = 0; k < NT; k++) begin
            if (clr) model[k] = 0;
            else if (pend[k] && model[k] < CMAX) model[k] = model[k] + 1;
            pend[k] = v && (mg >= thr[k]);
        end
        push_exp(tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #3;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                for (int k = 0; k < NT; k++) begin
                    int got, goth;
                    got  = int'(raw_counts[k*CW +: CW]);
                    goth = int'(half_counts[k*CW +: CW]);
                    tests++;
                    if (got != e.raw[k]) begin
                        fails++;
                        $display("FAIL %s ch%0d raw actual=%0d expected=%0d", e.tag, k, got, e.raw[k]);
                    end
                    tests++;
                    if (goth != e.raw[k] / 2) begin
                        fails++;
                        $display("FAIL R7 ch%0d half actual=%0d expected=%0d", k, goth, e.raw[k] / 2);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stimulus
        for (int k = 0; k < NT; k++) begin thr[k] = '0; model[k] = 0; pend[k] = 0; end
        do_reset(3);

        // R2 R3 R5: histogram thresholds 32/64/128/512
        thr[0] = 16'd32; thr[1] = 16'd64; thr[2] = 16'd128; thr[3] = 16'd512;
        drive(1, 16'd31,  0, "R3");
        drive(1, 16'd32,  0, "R2");
        drive(1, 16'd64,  0, "R5");
        drive(1, 16'd600, 0, "R5");
        drive(1, 16'd0,   0, "R3");
        drive(1, 16'd127, 0, "R2");
        drive(1, 16'd511, 0, "R5");

        // R4: large magnitudes without strobe
        for (int i = 0; i < 4; i++) drive(0, 16'hFFFF, 0, "R4");

        // R6: threshold changed the cycle after the sample
        drive(1, 16'd100, 0, "R6");
        thr[2] = 16'd50;
        drive(0, 16'd100, 0, "R6");
        drive(0, 16'd0,   0, "R6");
        drive(1, 16'd60,  0, "R6");
        drive(0, 16'd0,   0, "R6");

        // R3: full-range edge with all thresholds at maximum
        for (int k = 0; k < NT; k++) thr[k] = 16'hFFFF;
        drive(1, 16'hFFFE, 0, "R3");
        drive(1, 16'hFFFF, 0, "R3");
        drive(0, 16'd0,    0, "R3");
        drive(0, 16'd0,    0, "R3");

        // R8: clear collides with an increment, then a sample in the clear cycle
        drive(1, 16'hFFFF, 0, "R8");
        drive(0, 16'd0,    1, "R8");
        drive(0, 16'd0,    0, "R8");
        drive(1, 16'hFFFF, 1, "R8");
        drive(0, 16'd0,    0, "R8");
        drive(0, 16'd0,    0, "R8");

        // R10 R9: zero threshold counts everything until saturation
        thr[0] = 16'd0; thr[1] = 16'd1; thr[2] = 16'hFFFF; thr[3] = 16'hFFFF;
        drive(0, 16'd0, 1, "R10");
        for (int i = 0; i < 40; i++) drive(1, 16'd0, 0, (i < 30) ? "R10" : "R9");
        drive(0, 16'd0, 0, "R9");
        drive(0, 16'd0, 0, "R9");

        do_reset(2);
        drive(0, 16'd0, 0, "R1");

        @(posedge clk);
        #6;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule